// File: doc/BRIEF.md
# Serial Character Receiver with Retransmit Handshake

This block takes one character at a time from an upstream sender as a serial bitstream. It captures each frame bit by bit and checks the frame's parity. If the frame is clean, the block commits the 6-bit character. If not, it asks the sender to send the same character again. The sender holds a level, `tx_valid`, high while a frame is in flight. The block answers on two request lines: `req_ready` with `req_fresh` high asks for a new character, and `req_ready` with `req_fresh` low asks for the last character again.

The mode input selects one of two retransmit protocols. In deferred mode, a mid-frame drop of `tx_valid` is remembered, and the block keeps clocking in the frame; the retransmit is requested only after the last bit. In immediate mode, the same drop abandons the frame at once, and the next cycle requests a resend. The block spends one idle cycle after the last bit so the registered parity flag can settle, and judges the frame in the cycle after that.

Top module: `serial_char_rx`

## Requirements
- R1: While `restart` is high, and in the first cycle after it falls, `req_ready`, `req_fresh` and `commit` are low and `char_out` is zero. A restart taken in the middle of a frame abandons that frame.
- R2: After restart, the block asks for nothing while `tx_valid` is high. The cycle after it first samples `tx_valid` low, it shows `req_ready`=1 and `req_fresh`=1. It keeps showing them until it samples `tx_valid` high.
- R3: When a request is answered by `tx_valid` high, the next eight cycles each capture one `tx_bit`, least significant first. Frame bits 0 to 5 are the character, bit 6 is even parity over those six bits, and bit 7 is ignored.
- R4: A clean frame raises `commit` for exactly one cycle, the second cycle after the bit-7 cycle. `char_out` takes the character in the cycle after `commit`.
- R5: At the judging cycle of a clean frame, `tx_valid` low leads directly to a new-character request in the next cycle. `tx_valid` high leads back to the R2 wait.
- R6: A frame whose parity fails never commits. If `tx_valid` is low at the judging cycle, the next cycle shows `req_ready`=1 and `req_fresh`=0. If it is high, the block waits with both request lines low until it samples `tx_valid` low, and then shows the resend request.
- R7: In deferred mode (`cont_mode`=0), a low `tx_valid` during frame bits 0 to 6 does not interrupt capture. Both request lines stay low through the frame. After bit 7 the block does not commit; it waits for `tx_valid` low and then shows the resend request.
- R8: In immediate mode (`cont_mode`=1), a low `tx_valid` during frame bits 0 to 6 produces `req_ready`=1 and `req_fresh`=0 in the very next cycle, with no commit.
- R9: A resend request answered by `tx_valid` high starts a fresh capture. A drop remembered from the earlier frame has no effect on the new one.
- R10: `req_fresh` is never high without `req_ready`.
- R11: `char_out` changes only in the cycle after `commit`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| restart | input | 1 | Synchronous restart, active high |
| cont_mode | input | 1 | 0 = deferred retransmit, 1 = immediate retransmit |
| tx_valid | input | 1 | Sender's frame-in-flight level |
| tx_bit | input | 1 | Serial data bit |
| req_ready | output | 1 | Block is asking the sender for a frame |
| req_fresh | output | 1 | With req_ready: 1 = new character, 0 = resend |
| commit | output | 1 | One-cycle strobe for an accepted character |
| char_out | output | 6 | Last committed character |

## Verification
The bench goes after the judging cycle with `tx_valid` at both levels, for clean and corrupt frames. A design that returned to the idle wait regardless would stall one extra handshake, and one that skipped the wait after a corrupt frame would issue a resend request while the sender is still busy.

A deferred-mode drop is checked with both request lines held low through the rest of the frame. A design that aborted early would show a resend request mid-frame, and one that forgot the drop would commit a damaged character. The frame after that resend must commit, which catches a remembered drop that was never cleared.

In immediate mode, the resend request must appear in the cycle right after the drop; a late abort fails there. Frames with both values of the trailing bit must commit, which exposes a parity check that wrongly covers bit 7.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int DATA_W  = 6;
  localparam int FRAME_W = DATA_W + 2;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int ST_W    = 4;

  typedef enum logic [ST_W-1:0] {
    ST_ARM    = 4'd0,
    ST_REQ    = 4'd1,
    ST_B0     = 4'd2,
    ST_B1     = 4'd3,
    ST_B2     = 4'd4,
    ST_B3     = 4'd5,
    ST_B4     = 4'd6,
    ST_B5     = 4'd7,
    ST_B6     = 4'd8,
    ST_B7     = 4'd9,
    ST_SETTLE = 4'd10,
    ST_JUDGE  = 4'd11,
    ST_HOLD   = 4'd12,
    ST_RESEND = 4'd13
  } st_t;

  // even parity over data plus parity bit: a set result means corruption
  function automatic logic parity_bad(input logic [DATA_W-1:0] d, input logic p);
    return ^{d, p};
  endfunction

  // frame bits 0..6: the window where a drop of the valid level counts
  function automatic logic in_body(input st_t s);
    return (s >= ST_B0) && (s <= ST_B6);
  endfunction

  function automatic logic in_frame(input st_t s);
    return (s >= ST_B0) && (s <= ST_B7);
  endfunction
endpackage

// File: rtl/scr_capture.sv
module scr_capture
  import scr_pkg::*;
(
  input  logic              clk,
  input  logic              restart,
  input  logic              cap_en,
  input  logic [IDX_W-1:0]  cap_idx,
  input  logic              bit_in,
  output logic [DATA_W-1:0] data,
  output logic              err_q
);
  localparam int KEEP = FRAME_W - 1; // trailing bit is not stored

  logic [KEEP-1:0] frame;

  for (genvar i = 0; i < KEEP; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (restart)
        frame[i] <= 1'b0;
      else if (cap_en && (cap_idx == IDX_W'(i)))
        frame[i] <= bit_in;
    end
  end

  always_ff @(posedge clk) begin
    if (restart)
      err_q <= 1'b0;
    else
      err_q <= parity_bad(frame[DATA_W-1:0], frame[DATA_W]);
  end

  assign data = frame[DATA_W-1:0];
endmodule

// File: rtl/scr_ctrl.sv
module scr_ctrl
  import scr_pkg::*;
(
  input  logic             clk,
  input  logic             restart,
  input  logic             cont_mode,
  input  logic             valid,
  input  logic             err_q,
  output st_t              st,
  output logic             rep,
  output logic             cap_en,
  output logic [IDX_W-1:0] cap_idx,
  output logic             commit,
  output logic             ready,
  output logic             fresh
);
  st_t nxt;
  logic drop_now;

  assign drop_now = in_body(st) && !valid;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_ARM:    nxt = valid ? ST_ARM : ST_REQ;
      ST_REQ:    nxt = valid ? ST_B0 : ST_REQ;
      ST_SETTLE: nxt = ST_JUDGE;
      ST_JUDGE:
        if (err_q) nxt = valid ? ST_HOLD : ST_RESEND;
        else       nxt = valid ? ST_ARM  : ST_REQ;
      ST_HOLD:   nxt = valid ? ST_HOLD : ST_RESEND;
      ST_RESEND: nxt = valid ? ST_B0 : ST_RESEND;
      ST_B7:     nxt = (!cont_mode && rep) ? ST_HOLD : ST_SETTLE;
      default: begin
        if (cont_mode && drop_now) nxt = ST_RESEND;
        else                       nxt = st_t'(st + 4'd1);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (restart) st <= ST_ARM;
    else         st <= nxt;
  end

  always_ff @(posedge clk) begin
    if (restart)                     rep <= 1'b0;
    else if (nxt == ST_B0)           rep <= 1'b0;
    else if (!cont_mode && drop_now) rep <= 1'b1;
  end

  assign cap_en  = in_frame(st);
  assign cap_idx = IDX_W'(st - ST_B0);
  assign commit  = (st == ST_JUDGE) && !err_q;
  assign ready   = (st == ST_REQ) || (st == ST_RESEND);
  assign fresh   = (st == ST_REQ);
endmodule

// File: rtl/scr_hold.sv
module scr_hold
  import scr_pkg::*;
(
  input  logic              clk,
  input  logic              restart,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (restart)   dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx
  import scr_pkg::*;
(
  input  logic              clk,
  input  logic              restart,
  input  logic              cont_mode,
  input  logic              tx_valid,
  input  logic              tx_bit,
  output logic              req_ready,
  output logic              req_fresh,
  output logic              commit,
  output logic [DATA_W-1:0] char_out
);
  st_t              st_w;
  logic             rep_w;
  logic             err_w;
  logic             cap_en_w;
  logic [IDX_W-1:0] cap_idx_w;
  logic [DATA_W-1:0] data_w;

  scr_ctrl u_ctrl (
    .clk(clk), .restart(restart), .cont_mode(cont_mode), .valid(tx_valid),
    .err_q(err_w), .st(st_w), .rep(rep_w), .cap_en(cap_en_w),
    .cap_idx(cap_idx_w), .commit(commit), .ready(req_ready), .fresh(req_fresh)
  );

  scr_capture u_cap (
    .clk(clk), .restart(restart), .cap_en(cap_en_w), .cap_idx(cap_idx_w),
    .bit_in(tx_bit), .data(data_w), .err_q(err_w)
  );

  scr_hold u_hold (
    .clk(clk), .restart(restart), .load(commit), .din(data_w), .dout(char_out)
  );
endmodule

// File: rtl/scr_checker.sv
module scr_checker
  import scr_pkg::*;
(
  input logic              clk,
  input logic              restart,
  input logic              cont_mode,
  input logic              tx_valid,
  input logic [ST_W-1:0]   st,
  input logic              rep,
  input logic              err,
  input logic              commit,
  input logic              req_ready,
  input logic              req_fresh,
  input logic [DATA_W-1:0] char_out
);
  a_r10_fresh_needs_ready: assert property (@(posedge clk) disable iff (restart)
    req_fresh |-> req_ready);

  a_r4_commit_single: assert property (@(posedge clk) disable iff (restart)
    commit |=> !commit);

  a_r6_commit_only_clean: assert property (@(posedge clk) disable iff (restart)
    commit |-> (st == ST_JUDGE && !err));

  a_r11_char_stable: assert property (@(posedge clk) disable iff (restart)
    !commit |=> $stable(char_out));

  a_r2_arm_waits: assert property (@(posedge clk) disable iff (restart)
    (st == ST_ARM && tx_valid) |=> (st == ST_ARM));

  a_r8_immediate_abort: assert property (@(posedge clk) disable iff (restart)
    (cont_mode && st >= ST_B0 && st <= ST_B6 && !tx_valid) |=> (st == ST_RESEND));

  a_r7_deferred_resend: assert property (@(posedge clk) disable iff (restart)
    (!cont_mode && st == ST_B7 && rep) |=> (st == ST_HOLD));

  a_r9_flag_clear_on_start: assert property (@(posedge clk) disable iff (restart)
    (st == ST_B0) |-> !rep);
endmodule

bind serial_char_rx scr_checker u_chk (
  .clk(clk), .restart(restart), .cont_mode(cont_mode), .tx_valid(tx_valid),
  .st(st_w), .rep(rep_w), .err(err_w), .commit(commit),
  .req_ready(req_ready), .req_fresh(req_fresh), .char_out(char_out)
);

// File: tb/serial_char_rx_test.sv
module serial_char_rx_test;
  localparam int PERIOD = 10;
  localparam int DW = 6;

  logic clk = 1'b0;
  logic restart = 1'b1;
  logic cont_mode = 1'b0;
  logic tx_valid = 1'b1;
  logic tx_bit = 1'b0;
  logic req_ready, req_fresh, commit;
  logic [DW-1:0] char_out;

  int n_chk = 0;
  int n_bad = 0;
  int n_commit = 0;
  logic [DW-1:0] expq[$];
  bit pending = 1'b0;

  serial_char_rx uut (
    .clk(clk), .restart(restart), .cont_mode(cont_mode), .tx_valid(tx_valid),
    .tx_bit(tx_bit), .req_ready(req_ready), .req_fresh(req_fresh),
    .commit(commit), .char_out(char_out)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // frame per R3: data LSB first, even parity, then trailing bit
  function automatic logic [7:0] mkframe(input logic [DW-1:0] d, input bit good, input bit trail);
    logic p;
    p = ^d;
    if (!good) p = ~p;
    return {trail, p, d};
  endfunction

  // monitor: scoreboard compare of char_out the cycle after each commit
  always @(negedge clk) begin
    if (pending) begin
      logic [DW-1:0] e;
      e = expq.pop_front();
      chk(char_out == e, "R4 char_out after commit", int'(char_out), int'(e));
      pending = 1'b0;
    end
    if (!restart && commit) begin
      n_commit++;
      if (expq.size() == 0) chk(1'b0, "R6 unexpected commit", 1, 0);
      else pending = 1'b1;
    end
  end

  // called at a negedge while a request is shown; ends at negedge after judging
  task automatic send(input logic [DW-1:0] d, input bit good, input bit trail,
                      input bit end_valid);
    logic [7:0] f;
    f = mkframe(d, good, trail);
    if (good) expq.push_back(d);
    tx_valid = 1'b1;
    step();
    for (int i = 0; i < 8; i++) begin
      tx_bit = f[i];
      step();
      chk(!req_ready, "R3 no request during capture", int'(req_ready), 0);
    end
    tx_valid = end_valid;
    chk(!commit, "R4 no commit in settle cycle", int'(commit), 0);
    step();
    chk(commit == good, "R4 R6 commit at judging cycle", int'(commit), int'(good));
    step();
  endtask

  // frame with tx_valid low during bit idx; returns at negedge after abort/frame end
  task automatic send_drop(input logic [DW-1:0] d, input int idx);
    logic [7:0] f;
    f = mkframe(d, 1'b1, 1'b0);
    tx_valid = 1'b1;
    step();
    for (int i = 0; i < 8; i++) begin
      tx_bit = f[i];
      tx_valid = (i != idx);
      step();
      if (cont_mode) begin
        if (i == idx) begin
          chk(req_ready && !req_fresh, "R8 resend request right after drop",
              int'({req_ready, req_fresh}), 2);
          tx_valid = 1'b0;
          return;
        end
      end else begin
        chk(!req_ready && !req_fresh, "R7 capture continues after drop",
            int'({req_ready, req_fresh}), 0);
      end
    end
    tx_valid = 1'b1;
  endtask

  initial begin
    int c0;
    repeat (3) step();
    chk(!req_ready && !req_fresh && !commit && char_out == 0, "R1 reset state",
        int'({req_ready, req_fresh, commit}), 0);
    restart = 1'b0;
    step();
    chk(!req_ready && char_out == 0, "R1 state after restart falls", int'(req_ready), 0);
    repeat (3) step();
    chk(!req_ready, "R2 no request while valid high", int'(req_ready), 0);
    tx_valid = 1'b0;
    step();
    chk(req_ready && req_fresh, "R2 new request after valid low", int'({req_ready, req_fresh}), 3);
    step();
    chk(req_ready && req_fresh, "R2 request held", int'({req_ready, req_fresh}), 3);

    // clean frame, valid low at judging -> direct request
    send(6'h2D, 1'b1, 1'b0, 1'b0);
    chk(req_ready && req_fresh, "R5 direct new request", int'({req_ready, req_fresh}), 3);
    // clean frame, trailing bit set, valid high at judging -> wait
    send(6'h15, 1'b1, 1'b1, 1'b1);
    chk(!req_ready, "R5 wait after commit with valid high", int'(req_ready), 0);
    tx_valid = 1'b0;
    step();
    chk(req_ready && req_fresh, "R5 request after valid low", int'({req_ready, req_fresh}), 3);

    // parity error, valid high at judging
    c0 = n_commit;
    send(6'h07, 1'b0, 1'b0, 1'b1);
    chk(!req_ready, "R6 hold while valid high", int'(req_ready), 0);
    step();
    chk(!req_ready, "R6 still holding", int'(req_ready), 0);
    tx_valid = 1'b0;
    step();
    chk(req_ready && !req_fresh, "R6 resend request", int'({req_ready, req_fresh}), 2);
    chk(n_commit == c0, "R6 no commit on bad parity", n_commit, c0);
    send(6'h3F, 1'b1, 1'b0, 1'b0);
    chk(req_ready && req_fresh, "R9 resend committed", int'({req_ready, req_fresh}), 3);

    // parity error, valid low at judging -> direct resend
    send(6'h00, 1'b0, 1'b1, 1'b0);
    chk(req_ready && !req_fresh, "R6 direct resend request", int'({req_ready, req_fresh}), 2);

    // deferred mode drop
    c0 = n_commit;
    send_drop(6'h11, 3);
    chk(!req_ready, "R7 hold after deferred drop", int'(req_ready), 0);
    tx_valid = 1'b0;
    step();
    chk(req_ready && !req_fresh, "R7 resend after deferred drop", int'({req_ready, req_fresh}), 2);
    chk(n_commit == c0, "R7 no commit after drop", n_commit, c0);
    send(6'h11, 1'b1, 1'b0, 1'b0);
    chk(n_commit == c0 + 1, "R9 remembered drop cleared", n_commit, c0 + 1);

    // immediate mode
    cont_mode = 1'b1;
    send(6'h2A, 1'b1, 1'b1, 1'b0);
    c0 = n_commit;
    send_drop(6'h09, 2);
    chk(n_commit == c0, "R8 no commit after abort", n_commit, c0);
    send(6'h09, 1'b1, 1'b0, 1'b0);
    chk(n_commit == c0 + 1, "R9 resend after abort commits", n_commit, c0 + 1);

    // restart mid-frame
    tx_valid = 1'b1;
    step();
    tx_bit = 1'b1;
    repeat (3) step();
    restart = 1'b1;
    step();
    chk(!req_ready && char_out == 0, "R1 restart mid-frame", int'(char_out), 0);
    restart = 1'b0;
    step();
    chk(!req_ready && !commit, "R1 armed after restart", int'(req_ready), 0);
    repeat (12) step();
    chk(n_commit == c0 + 1 && expq.size() == 0, "R4 scoreboard drained", expq.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule